// File: doc/BRIEF.md
# Passive-Serial Configuration Loader

This block is the configuration-mode front end of a reconfigurable board. A host on a simple register bus starts a configuration cycle, waits until the target device is ready, and then writes the bitstream one byte at a time. The loader turns each byte into a serial stream on a data line with a matching configuration clock. It watches the target's status and done lines and reports them back to the host.

A start command pulls the target's configuration-request line low for a set number of clocks and then releases it. From the start command the loader measures the minimum settle interval (40 µs, counted in clocks). It then reports that it is ready, but only while the target's status line is high. The host polls the ready bit and then writes bytes. A byte written while the previous one is still shifting is held off: its acknowledge does not come until the shifter is free.

If the status line drops during loading, the transfer is aborted and a new start is needed. When the done line rises, the block switches itself to user mode. That mode is final until reset, and the ID byte then reports it.

Top module: `ps_cfg_loader`

## Requirements
- R1: After reset the configuration-request output is high, the configuration clock is low, the user-mode output is low and no acknowledge is given.
- R2: A read of offset 0AH returns 48H in configuration mode and 49H in user mode. A read of an unmapped offset (for example 05H) returns 00H.
- R3: A write to offset 00H with bit 0 set, made in configuration mode, drives the configuration-request output low for exactly NCFG_LOW_CYC clocks. The low pulse starts in the cycle in which the acknowledge is seen. The configuration clock stays low while the request is low.
- R4: Bit 0 of offset 00H reads 1 only in the ready state. That state is reached no sooner than WAIT_CYC clocks after the start acknowledge, and only while the status input is high. A read made earlier returns bit 0 as 0.
- R5: Bit 1 of offset 00H mirrors the status input and bit 2 mirrors the done input, each through a two-stage synchronizer. Bits 7..3 read 0.
- R6: In the ready state, each write to offset 02H shifts its byte out LSB first on the data output, with eight configuration-clock pulses. Each bit is presented one cycle before its rising edge, and the clock is high for one cycle and low for one cycle.
- R7: A data write that arrives while a byte is still shifting is acknowledged only once all eight bits of the previous byte have been clocked. A data write made while idle is acknowledged one cycle after it is presented.
- R8: A data write made while bit 0 reads 0 is acknowledged but produces no configuration-clock pulse.
- R9: If the status input falls in the ready state, shifting stops with the clock low, bit 0 clears, and later data writes produce no pulses until a new start.
- R10: If the done input rises in the ready state, the user-mode output goes high and stays high until reset. Start writes made afterwards leave the configuration-request output high.
- R11: Every acknowledge lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req_i | input | 1 | Bus request, held until acknowledged |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset |
| bus_wdata_i | input | DW | Write data |
| bus_ack_o | output | 1 | One-cycle acknowledge |
| bus_rdata_o | output | DW | Read data, valid with the acknowledge |
| ncfg_o | output | 1 | Configuration request to the target, active low |
| dclk_o | output | 1 | Configuration clock |
| data0_o | output | 1 | Serial configuration data |
| nstatus_i | input | 1 | Target status, low on error or during reset |
| conf_done_i | input | 1 | Target done flag |
| user_mode_o | output | 1 | High once the bus is handed to user mode |

## Verification
The assertions assume that the host holds the request and its address, direction and data stable until the acknowledge arrives, and drops the request in the cycle after it. The bench's bus task drives signals only on falling edges and releases them once it sees the acknowledge. The bench's target model pulls the status line low while the request line is low, and pulls it low in other cycles only when the test forces a fault. The done line is raised once, in the ready state, near the end of the run.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT,
        ST_READY,
        ST_USER
    } ld_state_e;

    localparam int OFS_CTRL = 'h0;
    localparam int OFS_DATA = 'h2;
    localparam int OFS_ID   = 'hA;
    localparam logic [7:0] ID_CFG  = 8'h48;
    localparam logic [7:0] ID_USER = 8'h49;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] byte_i,
    input  logic          abort_i,
    output logic          busy_o,
    output logic          dclk_o,
    output logic          data_o
);
    localparam int IDX_W = $clog2(DW);

    typedef struct packed {
        logic [DW-1:0]    sh;
        logic [IDX_W-1:0] idx;
        logic             ph;
        logic             busy;
        logic             dclk;
        logic             data;
    } shf_t;

    shf_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (abort_i) begin
            sh_d.busy = 1'b0;
            sh_d.dclk = 1'b0;
            sh_d.ph   = 1'b0;
        end else if (load_i) begin
            sh_d.sh   = byte_i;
            sh_d.data = byte_i[0];
            sh_d.dclk = 1'b0;
            sh_d.ph   = 1'b0;
            sh_d.idx  = '0;
            sh_d.busy = 1'b1;
        end else if (sh_q.busy) begin
            if (!sh_q.ph) begin
                sh_d.dclk = 1'b1;
                sh_d.ph   = 1'b1;
            end else begin
                sh_d.dclk = 1'b0;
                sh_d.ph   = 1'b0;
                if (sh_q.idx == IDX_W'(DW - 1)) begin
                    sh_d.busy = 1'b0;
                end else begin
                    sh_d.idx  = sh_q.idx + 1'b1;
                    sh_d.sh   = {1'b0, sh_q.sh[DW-1:1]};
                    sh_d.data = sh_q.sh[1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign busy_o = sh_q.busy;
    assign dclk_o = sh_q.dclk;
    assign data_o = sh_q.data;
endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader
    import cfg_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int DW           = 8,
    parameter int NCFG_LOW_CYC = 8,
    parameter int WAIT_CYC     = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic              bus_ack_o,
    output logic [DW-1:0]     bus_rdata_o,
    output logic              ncfg_o,
    output logic              dclk_o,
    output logic              data0_o,
    input  logic              nstatus_i,
    input  logic              conf_done_i,
    output logic              user_mode_o
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);

    typedef struct packed {
        ld_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic           ack;
        logic [DW-1:0]  rdata;
    } ld_t;

    ld_t ld_d, ld_q;

    logic [1:0] sync_out;
    logic       ns_s, cd_s;
    logic       sh_busy, sh_load, sh_abort;
    logic       start_hit, data_hit, accept;

    cfg_sync #(.W(2), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({conf_done_i, nstatus_i}),
        .dout (sync_out)
    );
    assign ns_s = sync_out[0];
    assign cd_s = sync_out[1];

    cfg_shifter #(.DW(DW)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sh_load),
        .byte_i (bus_wdata_i),
        .abort_i(sh_abort),
        .busy_o (sh_busy),
        .dclk_o (dclk_o),
        .data_o (data0_o)
    );

    always_comb begin
        ld_d     = ld_q;
        ld_d.ack = 1'b0;
        sh_load  = 1'b0;
        sh_abort = 1'b0;

        start_hit = bus_req_i && !ld_q.ack && bus_wr_i &&
                    (bus_addr_i == ADDR_W'(OFS_CTRL)) && bus_wdata_i[0];
        data_hit  = bus_req_i && !ld_q.ack && bus_wr_i &&
                    (bus_addr_i == ADDR_W'(OFS_DATA));
        accept    = bus_req_i && !ld_q.ack &&
                    !(data_hit && (ld_q.state == ST_READY) && sh_busy && ns_s && !cd_s);

        case (ld_q.state)
            ST_PULSE: begin
                ld_d.cnt = ld_q.cnt + 1'b1;
                if (ld_q.cnt == CNT_W'(NCFG_LOW_CYC - 1)) ld_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (ld_q.cnt < CNT_W'(WAIT_CYC)) ld_d.cnt = ld_q.cnt + 1'b1;
                else if (ns_s)                   ld_d.state = ST_READY;
            end
            ST_READY: begin
                if (!ns_s) begin
                    ld_d.state = ST_IDLE;
                    sh_abort   = 1'b1;
                end else if (cd_s) begin
                    ld_d.state = ST_USER;
                end else if (accept && data_hit) begin
                    sh_load = 1'b1;
                end
            end
            default: ;
        endcase

        if (accept && start_hit && (ld_q.state != ST_USER)) begin
            ld_d.state = ST_PULSE;
            ld_d.cnt   = '0;
            sh_abort   = 1'b1;
            sh_load    = 1'b0;
        end

        if (accept) begin
            ld_d.ack   = 1'b1;
            ld_d.rdata = '0;
            if (!bus_wr_i) begin
                if (bus_addr_i == ADDR_W'(OFS_CTRL))
                    ld_d.rdata = {{(DW-3){1'b0}}, cd_s, ns_s, ld_q.state == ST_READY};
                else if (bus_addr_i == ADDR_W'(OFS_ID))
                    ld_d.rdata = (ld_q.state == ST_USER) ? DW'(ID_USER) : DW'(ID_CFG);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q       <= '0;
            ld_q.state <= ST_IDLE;
        end else begin
            ld_q <= ld_d;
        end
    end

    assign bus_ack_o   = ld_q.ack;
    assign bus_rdata_o = ld_q.rdata;
    assign ncfg_o      = (ld_q.state != ST_PULSE);
    assign user_mode_o = (ld_q.state == ST_USER);
endmodule

// File: rtl/ps_cfg_loader_chk.sv
module ps_cfg_loader_chk #(
    parameter int ADDR_W   = 4,
    parameter int DW       = 8,
    parameter int WAIT_CYC = 4000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DW-1:0]     bus_wdata_i,
    input logic              bus_ack_o,
    input logic [DW-1:0]     bus_rdata_o,
    input logic              ncfg_o,
    input logic              dclk_o,
    input logic              data0_o,
    input logic              user_mode_o
);
    localparam int CW = $clog2(WAIT_CYC + 2);

    logic          seen_q;
    logic [CW-1:0] since_q;
    logic          start_ack, ctrl_rd_ack, data_wr_ack;

    assign start_ack   = bus_ack_o && bus_wr_i && (bus_addr_i == ADDR_W'(0)) &&
                         bus_wdata_i[0] && !user_mode_o;
    assign ctrl_rd_ack = bus_ack_o && !bus_wr_i && (bus_addr_i == ADDR_W'(0));
    assign data_wr_ack = bus_ack_o && bus_wr_i && (bus_addr_i == ADDR_W'(2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            since_q <= '0;
        end else if (start_ack) begin
            seen_q  <= 1'b1;
            since_q <= CW'(1);
        end else if (since_q < CW'(WAIT_CYC + 1)) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r3_no_clock_during_request: assert property (@(posedge clk) disable iff (!rst_n)
        !ncfg_o |-> !dclk_o);
    a_r4_ready_after_interval: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd_ack && bus_rdata_o[0]) |-> (seen_q && since_q >= CW'(WAIT_CYC)));
    a_r6_data_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_o) |-> $stable(data0_o));
    a_r6_clock_high_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_o |=> !dclk_o);
    a_r7_accept_with_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_ack |-> !dclk_o);
    a_r10_user_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode_o |=> user_mode_o);
    a_r10_no_request_in_user: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode_o |-> ncfg_o);
    a_r11_ack_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_o |=> !bus_ack_o);
endmodule

bind ps_cfg_loader ps_cfg_loader_chk #(
    .ADDR_W(ADDR_W), .DW(DW), .WAIT_CYC(WAIT_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_ack_o  (bus_ack_o),
    .bus_rdata_o(bus_rdata_o),
    .ncfg_o     (ncfg_o),
    .dclk_o     (dclk_o),
    .data0_o    (data0_o),
    .user_mode_o(user_mode_o)
);

// File: tb/ps_cfg_loader_bench.sv
module ps_cfg_loader_bench;
    localparam int L = 8;
    localparam int W = 4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, wr = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       ack, ncfg, dclk, data0, user_mode;
    logic [7:0] rdata;
    logic       fault = 1'b0, cdone = 1'b0;
    wire        nstatus = ncfg && !fault;

    ps_cfg_loader u_ps_cfg_loader (
        .clk(clk), .rst_n(rst_n), .bus_req_i(req), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_ack_o(ack),
        .bus_rdata_o(rdata), .ncfg_o(ncfg), .dclk_o(dclk), .data0_o(data0),
        .nstatus_i(nstatus), .conf_done_i(cdone), .user_mode_o(user_mode)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    longint cyc = 0;
    int rises = 0, bitn = 0, lowcnt = 0;
    logic prev_dclk = 1'b0;
    logic [7:0] acc;
    logic [7:0] expq[$];
    logic [7:0] capq[$];

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (!ncfg) lowcnt++;
        if (dclk && !prev_dclk) begin
            rises++;
            acc[bitn] = data0;
            bitn++;
            if (bitn == 8) begin
                capq.push_back(acc);
                bitn = 0;
            end
        end
        prev_dclk = dclk;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [3:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int wt);
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d; wt = 0;
        do begin
            @(negedge clk);
            wt++;
        end while (!ack && wt < 200);
        if (!ack) check("R11 ack timeout", 0, 1);
        rd = rdata;
        req = 1'b0;
        @(negedge clk);
        check("R11 ack one cycle", ack, 0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_and_wait();
        logic [7:0] r;
        int wt;
        longint t0;
        lowcnt = 0;
        xfer(1'b1, 4'h0, 8'h01, r, wt);
        t0 = cyc;
        xfer(1'b0, 4'h0, 8'h00, r, wt);
        check("R4 bit0 low right after start", r[0], 0);
        idle(30);
        check("R3 request low length", lowcnt, L);
        while (cyc < t0 + W - 30) @(negedge clk);
        xfer(1'b0, 4'h0, 8'h00, r, wt);
        check("R4 bit0 low before interval", r[0], 0);
        while (cyc < t0 + W + 20) @(negedge clk);
        xfer(1'b0, 4'h0, 8'h00, r, wt);
        check("R4 R5 ready with status high", r, 8'h03);
    endtask

    task automatic send(input logic [7:0] b, input int gap, input int first);
        logic [7:0] r;
        int wt;
        expq.push_back(b);
        xfer(1'b1, 4'h2, b, r, wt);
        if (first != 0) check("R7 idle write ack after one cycle", wt, 1);
        else check("R7 held-off wait bounded", (wt >= 1 && wt <= 18), 1);
        check("R7 previous byte complete at ack", capq.size(), expq.size() - 1);
        idle(gap);
    endtask

    task automatic compare_all();
        check("R6 byte count", capq.size(), expq.size());
        foreach (expq[i]) begin
            if (i < capq.size()) check("R6 serial byte LSB first", capq[i], expq[i]);
        end
    endtask

    initial begin
        logic [7:0] r;
        int wt, r0;
        void'($urandom(32'd2024));
        idle(5);
        rst_n = 1'b1;
        idle(1);
        check("R1 request high", ncfg, 1);
        check("R1 clock low", dclk, 0);
        check("R1 user mode low", user_mode, 0);
        check("R1 no ack", ack, 0);

        xfer(1'b0, 4'hA, 8'h00, r, wt);
        check("R2 id in config mode", r, 8'h48);
        xfer(1'b0, 4'h5, 8'h00, r, wt);
        check("R2 unmapped reads zero", r, 8'h00);
        xfer(1'b0, 4'h0, 8'h00, r, wt);
        check("R5 status mirror idle", r, 8'h02);

        r0 = rises;
        xfer(1'b1, 4'h2, 8'h5A, r, wt);
        idle(40);
        check("R8 no pulses before ready", rises - r0, 0);

        start_and_wait();

        send(8'h01, 30, 1);
        send(8'h80, 0, 0);
        send(8'hA5, 0, 0);
        send(8'hFF, 0, 0);
        send(8'h00, 0, 0);
        for (int i = 0; i < 20; i++) begin
            int g;
            g = (($urandom % 4) == 0) ? int'($urandom_range(0, 10)) : 0;
            send(8'($urandom), g, 0);
        end
        idle(30);
        compare_all();
        check("R6 pulse total", rises, 8 * expq.size());

        xfer(1'b1, 4'h2, 8'h3C, r, wt);
        idle(4);
        fault = 1'b1;
        idle(6);
        check("R9 clock low after abort", dclk, 0);
        r0 = rises;
        idle(30);
        check("R9 no pulses while aborted", rises - r0, 0);
        xfer(1'b0, 4'h0, 8'h00, r, wt);
        check("R9 R5 status low and ready cleared", r, 8'h00);
        fault = 1'b0;
        bitn = 0;
        idle(5);
        r0 = rises;
        xfer(1'b1, 4'h2, 8'h77, r, wt);
        idle(30);
        check("R9 data ignored after abort", rises - r0, 0);

        start_and_wait();
        capq.delete();
        expq.delete();
        send(8'hC3, 0, 1);
        send(8'($urandom), 0, 0);
        send(8'h96, 0, 0);
        idle(30);
        compare_all();

        cdone = 1'b1;
        idle(6);
        check("R10 user mode entered", user_mode, 1);
        xfer(1'b0, 4'hA, 8'h00, r, wt);
        check("R2 R10 id in user mode", r, 8'h49);
        xfer(1'b0, 4'h0, 8'h00, r, wt);
        check("R5 done mirrored", r, 8'h06);
        lowcnt = 0;
        xfer(1'b1, 4'h0, 8'h01, r, wt);
        idle(20);
        check("R10 start ignored in user mode", lowcnt, 0);
        check("R10 user mode held", user_mode, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule